// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the home-side bookkeeping for an invalidation-based cache coherence protocol. It keeps, for every memory block homed here, one presence bit per node and a dirty bit. Nodes send it read requests and read-exclusive requests. It answers each one of three ways. It can reply at once with data or a write grant. It can send recall or invalidate messages to the caches that hold the block and finish the transaction once their acknowledgements come back. Or it can reject the request with a negative acknowledgement so that the node retries.

One transaction engine carries all the work that needs the network. While it is waiting, its block is busy and every request to that block is rejected. Other blocks are still served as long as their requests can be answered without the engine. Each request carries a small priority field, and a node raises that field each time it is rejected. The controller keeps a single reservation that holds the highest raised priority and the block it belongs to. Requests to that block below the reserved priority are rejected until a request at or above it claims the block, so a node that keeps losing the race cannot starve.

Top module: `home_directory`

## Requirements
- R1: After reset every entry is empty and clean, the engine is idle and no reply, forward or completion is driven.
- R2: A read to a clean block, or a read from the node that already owns it, returns data on the reply port one cycle after the request (rspKind 0 = data) and sets the requester's presence bit.
- R3: A read to a dirty block owned by another node sends one recall (fwdKind 0) to the owner alone, one cycle after the request. After one acknowledgement the block is clean and held by both owner and requester, and data goes to the requester on the completion port (doneKind 0).
- R4: A read-exclusive request sends invalidations (fwdKind 1) one cycle later. The target vector has bit i set for each node i whose presence bit is set, except the requester.
- R5: A read-exclusive request to a block held by no other node is granted on the reply port one cycle after the request (rspKind 1 = grant). The block becomes dirty and is held by the requester alone.
- R6: The acknowledgement counter is loaded with the number of targets. The exclusive grant (doneKind 1) appears on the completion port exactly one cycle after the last acknowledgement and never earlier.
- R7: Each request gets exactly one reply or one forward, one cycle after it arrives. A request is rejected (rspKind 2 = nack) when its block is busy, or when it would need the engine while the engine is busy. Requests that need no engine are still served while the engine is busy.
- R8: A rejected request of priority p leaves a reservation for its block at priority p+1 when no reservation exists or p+1 is higher than the one held. Requests to that block below the reserved priority are rejected. The first request at or above it is admitted and clears the reservation.
- R9: The priority field is 3 bits wide and the raised value saturates at 7, so a rejected request of priority 7 reserves 7.
- R10: An acknowledgement that arrives while the engine is idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqNode | input | NODE_W | Requesting node |
| reqBlock | input | BLK_W | Block index |
| reqExcl | input | 1 | 1 = read-exclusive, 0 = read |
| reqPrio | input | PRIO_W | Requester priority |
| ackValid | input | 1 | One recall or invalidation acknowledgement |
| rspValid | output | 1 | Immediate reply valid |
| rspNode | output | NODE_W | Reply destination |
| rspBlock | output | BLK_W | Reply block |
| rspKind | output | 2 | 0 data, 1 grant, 2 nack |
| fwdValid | output | 1 | Recall/invalidate message valid |
| fwdKind | output | 1 | 0 recall, 1 invalidate |
| fwdBlock | output | BLK_W | Block being recalled or invalidated |
| fwdTargets | output | NODES | Destination node vector |
| doneValid | output | 1 | Completed engine transaction |
| doneNode | output | NODE_W | Completion destination |
| doneBlock | output | BLK_W | Completion block |
| doneKind | output | 2 | 0 data, 1 grant |

## Verification
The bench builds the block with four nodes and eight blocks. With so few, a random stream of reads and writes keeps returning to the same blocks. That drives every transition between clean sharing, a dirty owner and the recall and invalidation paths. Four nodes also let an invalidation wait on three acknowledgements. Directed sequences overlap requests with an open transaction, to reach the busy rejects, the reservation and the saturated priority of 7.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [1:0] {
    RSP_DATA  = 2'd0,
    RSP_GRANT = 2'd1,
    RSP_NACK  = 2'd2
  } rspKind_e;

  typedef enum logic {
    FWD_RECALL = 1'b0,
    FWD_INVAL  = 1'b1
  } fwdKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic reqWrite;   // immediate update of the requested entry
    logic doneWrite;  // update of the engine's entry at completion
    logic cntLoad;    // load ack counter from target population
    logic cntDec;     // one acknowledgement consumed
  } dpStrobe_t;

endpackage

// File: rtl/dir_datapath.sv
module dir_datapath
  import dir_pkg::*;
#(
  parameter int NODES  = 8,
  parameter int BLOCKS = 32,
  localparam int BLK_W = $clog2(BLOCKS),
  localparam int CNT_W = $clog2(NODES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [BLK_W-1:0] reqBlock,
  input  logic [BLK_W-1:0] engBlock,
  input  logic [NODES-1:0] reqPresNew,
  input  logic             reqDirtyNew,
  input  logic [NODES-1:0] donePresNew,
  input  logic             doneDirtyNew,
  input  logic [NODES-1:0] loadMask,
  output logic [NODES-1:0] reqPres,
  output logic             reqDirty,
  output logic [NODES-1:0] engPres,
  output logic             cntOne
);

  logic [NODES-1:0] presMem  [BLOCKS];
  logic             dirtyMem [BLOCKS];
  logic [CNT_W-1:0] ackCnt;
  logic [CNT_W-1:0] maskCount;

  for (genvar b = 0; b < BLOCKS; b++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        presMem[b]  <= '0;
        dirtyMem[b] <= 1'b0;
      end else if (strobe.doneWrite && engBlock == BLK_W'(b)) begin
        presMem[b]  <= donePresNew;
        dirtyMem[b] <= doneDirtyNew;
      end else if (strobe.reqWrite && reqBlock == BLK_W'(b)) begin
        presMem[b]  <= reqPresNew;
        dirtyMem[b] <= reqDirtyNew;
      end
    end
  end

  assign reqPres  = presMem[reqBlock];
  assign reqDirty = dirtyMem[reqBlock];
  assign engPres  = presMem[engBlock];

  always_comb begin
    maskCount = '0;
    for (int i = 0; i < NODES; i++) maskCount = maskCount + CNT_W'(loadMask[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN)              ackCnt <= '0;
    else if (strobe.cntLoad) ackCnt <= maskCount;
    else if (strobe.cntDec && ackCnt != '0) ackCnt <= ackCnt - 1'b1;
  end

  assign cntOne = (ackCnt == CNT_W'(1));

endmodule

// File: rtl/dir_control.sv
module dir_control
  import dir_pkg::*;
#(
  parameter int NODES  = 8,
  parameter int BLOCKS = 32,
  parameter int PRIO_W = 3,
  localparam int NODE_W = $clog2(NODES),
  localparam int BLK_W  = $clog2(BLOCKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [NODE_W-1:0] reqNode,
  input  logic [BLK_W-1:0]  reqBlock,
  input  logic              reqExcl,
  input  logic [PRIO_W-1:0] reqPrio,
  input  logic              ackValid,
  input  logic [NODES-1:0]  reqPres,
  input  logic              reqDirty,
  input  logic [NODES-1:0]  engPres,
  input  logic              cntOne,
  output dpStrobe_t         strobe,
  output logic [BLK_W-1:0]  engBlock,
  output logic [NODES-1:0]  reqPresNew,
  output logic              reqDirtyNew,
  output logic [NODES-1:0]  donePresNew,
  output logic              doneDirtyNew,
  output logic [NODES-1:0]  loadMask,
  output logic              rspValid,
  output logic [NODE_W-1:0] rspNode,
  output logic [BLK_W-1:0]  rspBlock,
  output logic [1:0]        rspKind,
  output logic              fwdValid,
  output logic              fwdKind,
  output logic [BLK_W-1:0]  fwdBlock,
  output logic [NODES-1:0]  fwdTargets,
  output logic              doneValid,
  output logic [NODE_W-1:0] doneNode,
  output logic [BLK_W-1:0]  doneBlock,
  output logic [1:0]        doneKind
);

  logic              busy;
  logic [NODE_W-1:0] engNode;
  logic              engExcl;
  logic              resValid;
  logic [BLK_W-1:0]  resBlock;
  logic [PRIO_W-1:0] resPrio;

  logic [NODES-1:0]  reqBit, engBit, others;
  logic              needEngine, blockBusy, resDenies, nack, accept, completing;
  logic [PRIO_W-1:0] raisedPrio;

  always_comb begin
    reqBit = '0;
    reqBit[reqNode] = 1'b1;
    engBit = '0;
    engBit[engNode] = 1'b1;
  end

  assign others     = reqPres & ~reqBit;
  assign needEngine = reqExcl ? (|others) : (reqDirty && !reqPres[reqNode]);
  assign blockBusy  = busy && (engBlock == reqBlock);
  assign resDenies  = resValid && (resBlock == reqBlock) && (reqPrio < resPrio);
  assign nack       = reqValid && (blockBusy || (busy && needEngine) || resDenies);
  assign accept     = reqValid && !nack;
  assign completing = busy && ackValid && cntOne;
  assign raisedPrio = (reqPrio == {PRIO_W{1'b1}}) ? reqPrio : reqPrio + 1'b1;

  always_comb begin
    strobe.reqWrite  = accept && !needEngine;
    strobe.doneWrite = completing;
    strobe.cntLoad   = accept && needEngine;
    strobe.cntDec    = busy && ackValid;
    reqPresNew   = reqExcl ? reqBit : (reqPres | reqBit);
    reqDirtyNew  = reqExcl ? 1'b1 : reqDirty;
    donePresNew  = engExcl ? engBit : (engPres | engBit);
    doneDirtyNew = engExcl;
    loadMask     = reqExcl ? others : reqPres;
  end

  // engine and reservation state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      engBlock <= '0;
      engNode  <= '0;
      engExcl  <= 1'b0;
      resValid <= 1'b0;
      resBlock <= '0;
      resPrio  <= '0;
    end else begin
      if (strobe.cntLoad) begin
        busy     <= 1'b1;
        engBlock <= reqBlock;
        engNode  <= reqNode;
        engExcl  <= reqExcl;
      end else if (completing) begin
        busy <= 1'b0;
      end
      if (accept && resValid && resBlock == reqBlock) begin
        resValid <= 1'b0;
      end else if (nack && (!resValid || raisedPrio > resPrio)) begin
        resValid <= 1'b1;
        resBlock <= reqBlock;
        resPrio  <= raisedPrio;
      end
    end
  end

  // registered message outputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspNode    <= '0;
      rspBlock   <= '0;
      rspKind    <= RSP_DATA;
      fwdValid   <= 1'b0;
      fwdKind    <= FWD_RECALL;
      fwdBlock   <= '0;
      fwdTargets <= '0;
      doneValid  <= 1'b0;
      doneNode   <= '0;
      doneBlock  <= '0;
      doneKind   <= RSP_DATA;
    end else begin
      rspValid  <= reqValid && !strobe.cntLoad;
      rspNode   <= reqNode;
      rspBlock  <= reqBlock;
      rspKind   <= nack ? RSP_NACK : (reqExcl ? RSP_GRANT : RSP_DATA);
      fwdValid  <= strobe.cntLoad;
      fwdKind   <= reqExcl ? FWD_INVAL : FWD_RECALL;
      fwdBlock  <= reqBlock;
      fwdTargets <= strobe.cntLoad ? loadMask : '0;
      doneValid <= completing;
      doneNode  <= engNode;
      doneBlock <= engBlock;
      doneKind  <= engExcl ? RSP_GRANT : RSP_DATA;
    end
  end

endmodule

// File: rtl/home_directory.sv
module home_directory
  import dir_pkg::*;
#(
  parameter int NODES  = 8,
  parameter int BLOCKS = 32,
  parameter int PRIO_W = 3,
  localparam int NODE_W = $clog2(NODES),
  localparam int BLK_W  = $clog2(BLOCKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [NODE_W-1:0] reqNode,
  input  logic [BLK_W-1:0]  reqBlock,
  input  logic              reqExcl,
  input  logic [PRIO_W-1:0] reqPrio,
  input  logic              ackValid,
  output logic              rspValid,
  output logic [NODE_W-1:0] rspNode,
  output logic [BLK_W-1:0]  rspBlock,
  output logic [1:0]        rspKind,
  output logic              fwdValid,
  output logic              fwdKind,
  output logic [BLK_W-1:0]  fwdBlock,
  output logic [NODES-1:0]  fwdTargets,
  output logic              doneValid,
  output logic [NODE_W-1:0] doneNode,
  output logic [BLK_W-1:0]  doneBlock,
  output logic [1:0]        doneKind
);

  dpStrobe_t        strobe;
  logic [BLK_W-1:0] engBlock;
  logic [NODES-1:0] reqPresNew, donePresNew, loadMask, reqPres, engPres;
  logic             reqDirtyNew, doneDirtyNew, reqDirty, cntOne;

  dir_control #(.NODES(NODES), .BLOCKS(BLOCKS), .PRIO_W(PRIO_W)) ctrl_i (
    .clk, .rstN, .reqValid, .reqNode, .reqBlock, .reqExcl, .reqPrio, .ackValid,
    .reqPres, .reqDirty, .engPres, .cntOne,
    .strobe, .engBlock, .reqPresNew, .reqDirtyNew, .donePresNew, .doneDirtyNew, .loadMask,
    .rspValid, .rspNode, .rspBlock, .rspKind,
    .fwdValid, .fwdKind, .fwdBlock, .fwdTargets,
    .doneValid, .doneNode, .doneBlock, .doneKind
  );

  dir_datapath #(.NODES(NODES), .BLOCKS(BLOCKS)) dp_i (
    .clk, .rstN, .strobe, .reqBlock, .engBlock,
    .reqPresNew, .reqDirtyNew, .donePresNew, .doneDirtyNew, .loadMask,
    .reqPres, .reqDirty, .engPres, .cntOne
  );

endmodule

// File: rtl/dir_checker.sv
module dir_checker #(
  parameter int NODES  = 8,
  parameter int BLOCKS = 32,
  parameter int PRIO_W = 3,
  localparam int NODE_W = $clog2(NODES),
  localparam int BLK_W  = $clog2(BLOCKS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [NODE_W-1:0] reqNode,
  input logic              ackValid,
  input logic              rspValid,
  input logic              fwdValid,
  input logic              fwdKind,
  input logic [NODES-1:0]  fwdTargets,
  input logic              doneValid
);

  // R7: each request yields exactly one of reply or forward next cycle
  p_one_answer_r7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (rspValid != fwdValid));

  // R3: a recall goes to exactly one owner
  p_recall_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid && !fwdKind) |-> ($countones(fwdTargets) == 1));

  // R4: invalidations never target the requester
  p_inval_skip_self_r4: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid && fwdKind) |-> (fwdTargets[$past(reqNode)] == 1'b0));

  // R6: a completion always follows an acknowledgement
  p_done_after_ack_r6: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> $past(ackValid));

  // R6: a forward and a completion never coincide
  p_no_fwd_with_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(fwdValid && doneValid));

endmodule

bind home_directory dir_checker #(.NODES(NODES), .BLOCKS(BLOCKS), .PRIO_W(PRIO_W)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqNode(reqNode), .ackValid(ackValid),
  .rspValid(rspValid), .fwdValid(fwdValid), .fwdKind(fwdKind),
  .fwdTargets(fwdTargets), .doneValid(doneValid)
);

// File: tb/home_directory_tb.sv
`timescale 1ns/1ps
module home_directory_tb_top;

  localparam int NODES = 4;
  localparam int BLOCKS = 8;
  localparam int PRIO_W = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqNode = '0;
  logic [2:0] reqBlock = '0;
  logic reqExcl = 1'b0;
  logic [2:0] reqPrio = '0;
  logic ackValid = 1'b0;
  logic rspValid, fwdValid, fwdKind, doneValid;
  logic [1:0] rspNode, rspKind, doneNode, doneKind;
  logic [2:0] rspBlock, fwdBlock, doneBlock;
  logic [3:0] fwdTargets;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit finished = 0;

  logic [3:0] mPres [BLOCKS];
  logic       mDirty[BLOCKS];
  bit         pendValid = 0;
  logic [1:0] pendNode;
  logic [2:0] pendBlk;
  bit         pendExcl;
  int         pendCnt = 0;

  home_directory #(.NODES(NODES), .BLOCKS(BLOCKS), .PRIO_W(PRIO_W)) dut_i (
    .clk, .rstN, .reqValid, .reqNode, .reqBlock, .reqExcl, .reqPrio, .ackValid,
    .rspValid, .rspNode, .rspBlock, .rspKind,
    .fwdValid, .fwdKind, .fwdBlock, .fwdTargets,
    .doneValid, .doneNode, .doneBlock, .doneKind
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      mismatched++;
      $display("FAIL watchdog (all requirements) actual=%0d cycles expected=done", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic check(string tag, bit ok, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sendReq(int node, int blk, bit excl, int prio);
    @(negedge clk);
    reqValid = 1'b1;
    reqNode  = 2'(node);
    reqBlock = 3'(blk);
    reqExcl  = excl;
    reqPrio  = 3'(prio);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic expectNack(string tag, int node, int blk, bit excl, int prio);
    sendReq(node, blk, excl, prio);
    check(tag, rspValid && !fwdValid && rspKind == 2'd2 && rspNode == 2'(node),
          {rspValid, fwdValid, rspKind}, 6'b10_0010);
  endtask

  // serve a request the model expects to be admitted
  task automatic doServe(string tag, int node, int blk, bit excl, int prio);
    logic [3:0] bitV, oth;
    bitV = 4'b1 << node;
    oth  = mPres[blk] & ~bitV;
    sendReq(node, blk, excl, prio);
    if (excl && oth == 0) begin
      check(tag, rspValid && !fwdValid && rspKind == 2'd1 && rspNode == 2'(node),
            {rspValid, fwdValid, rspKind}, 4'b1001);
      mPres[blk] = bitV; mDirty[blk] = 1'b1;
    end else if (excl) begin
      check(tag, fwdValid && !rspValid && fwdKind && fwdTargets == oth && fwdBlock == 3'(blk),
            {fwdValid, fwdKind, fwdTargets}, {2'b11, oth});
      pendValid = 1; pendNode = 2'(node); pendBlk = 3'(blk); pendExcl = 1;
      pendCnt = $countones(oth);
    end else if (mDirty[blk] && !mPres[blk][node]) begin
      check(tag, fwdValid && !rspValid && !fwdKind && fwdTargets == mPres[blk],
            {fwdValid, fwdKind, fwdTargets}, {2'b10, mPres[blk]});
      pendValid = 1; pendNode = 2'(node); pendBlk = 3'(blk); pendExcl = 0; pendCnt = 1;
    end else begin
      check(tag, rspValid && !fwdValid && rspKind == 2'd0 && rspNode == 2'(node) &&
            rspBlock == 3'(blk), {rspValid, fwdValid, rspKind}, 4'b1000);
      mPres[blk] = mPres[blk] | bitV;
    end
  endtask

  task automatic ackStep(string tag);
    @(negedge clk);
    ackValid = 1'b1;
    @(negedge clk);
    ackValid = 1'b0;
    pendCnt--;
    if (pendCnt == 0) begin
      check(tag, doneValid && doneNode == pendNode && doneBlock == pendBlk &&
            doneKind == (pendExcl ? 2'd1 : 2'd0), {doneValid, doneKind}, {1'b1, 1'b0, pendExcl});
      if (pendExcl) begin
        mPres[pendBlk] = 4'b1 << pendNode; mDirty[pendBlk] = 1'b1;
      end else begin
        mPres[pendBlk] = mPres[pendBlk] | (4'b1 << pendNode); mDirty[pendBlk] = 1'b0;
      end
      pendValid = 0;
    end else begin
      check(tag, !doneValid, doneValid, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd5150));
    for (int b = 0; b < BLOCKS; b++) begin mPres[b] = '0; mDirty[b] = 1'b0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: quiet after reset
    check("R1 reset outputs", !rspValid && !fwdValid && !doneValid,
          {rspValid, fwdValid, doneValid}, 0);
    // R10: stray ack while idle
    @(negedge clk); ackValid = 1'b1;
    @(negedge clk); ackValid = 1'b0;
    check("R10 idle ack no completion", !doneValid, doneValid, 0);
    // R1/R2: fresh block answers from memory; three sharers
    doServe("R1 R2 first read", 0, 1, 0, 0);
    doServe("R2 read second sharer", 1, 1, 0, 0);
    doServe("R2 read third sharer", 2, 1, 0, 0);
    // R4 R6: write by sharer invalidates the other two
    doServe("R4 inval targets", 1, 1, 1, 0);
    ackStep("R6 no early grant");
    expectNack("R7 busy block nack", 3, 1, 0, 0);
    doServe("R7 clean read served while busy", 3, 2, 0, 0);
    doServe("R5 grant on empty block while busy", 3, 3, 1, 0);
    expectNack("R7 engine busy nack", 0, 3, 0, 0);
    ackStep("R6 grant after last ack");
    // R8: reservation at priority 1 on block 1
    expectNack("R8 below reservation nack", 0, 1, 0, 0);
    doServe("R3 R8 recall on reserved claim", 3, 1, 0, 1);
    ackStep("R3 data after recall");
    doServe("R8 reservation cleared", 0, 1, 0, 0);
    // R6: three acknowledgements
    doServe("R4 inval three sharers", 2, 1, 1, 0);
    ackStep("R6 ack one of three");
    repeat (2) @(negedge clk);
    ackStep("R6 ack two of three");
    ackStep("R6 ack three of three");
    // R9: saturation
    doServe("R4 inval owner", 0, 1, 1, 0);
    expectNack("R9 nack prio7", 3, 1, 0, 7);
    expectNack("R9 nack prio6 busy", 1, 1, 0, 6);
    ackStep("R6 grant node0");
    expectNack("R9 reservation holds 7", 1, 1, 0, 6);
    doServe("R9 prio7 admitted", 1, 1, 0, 7);
    ackStep("R3 recall data node1");
    // R5: owner-only writes
    doServe("R5 grant empty", 2, 5, 1, 0);
    doServe("R5 grant repeat owner", 2, 5, 1, 0);
    // R2 owner reading its own dirty line
    doServe("R2 owner read", 2, 5, 0, 0);
    // random mix
    for (int i = 0; i < 300; i++) begin
      doServe("R2-random", int'($urandom % 4), int'($urandom % 8), bit'($urandom % 2), 0);
      while (pendValid) begin
        repeat (int'($urandom % 3)) @(negedge clk);
        ackStep("R6 random ack");
      end
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule